// File: doc/BRIEF.md
# Hybrid DC Breaker Sequencing Controller

This block sequences the switches of a bidirectional hybrid DC circuit breaker. It samples a signed line current and a signed capacitor voltage each clock. When the current magnitude passes a programmable trip level, the controller opens the main mechanical switch. At the same moment it gates the thyristor pair that matches the sign of the fault, so that the pre-charged capacitor injects a counter-current. The capacitor is never flipped before this injection starts.

Once the line current is back inside a zero band, the controller removes the gates and opens the residual disconnector. It then restores the capacitor to its rated positive charge, using a dump resistor path, a polarity-flip thyristor, or both. After that it recloses. A millisecond tick drives a down-counter, and no state that waits on a mechanical switch is left before that counter has run out. Each completed interruption is counted. When the count has reached its limit and one more interruption completes, the breaker stays open in a lockout state until reset.

Top module: `dc_breaker_seq`

## Requirements
- R1: After reset, `mode` is 0, `trip_count` is 0 and `lockout` is 0. The mode codes are: 0 normal, 1 breaking, 2 isolating, 3 discharging, 4 reversing, 5 reclosing, 6 lockout.
- R2: In normal mode (0), and in reclosing mode (5), `disc_close` and `main_close` are 1. `dump_close` and all five gate outputs are 0.
- R3: In normal mode, a trip occurs only when |i_line| > trip_lvl, for either sign. A magnitude equal to trip_lvl causes no trip. The mode becomes 1 one clock after the offending sample.
- R4: In breaking mode, `main_close` is 0 and `disc_close` is 1. A positive fault gates `gate_pos_a` and `gate_pos_b` and sets `fault_neg` to 0. A negative fault gates `gate_neg_a` and `gate_neg_b` and sets `fault_neg` to 1. The other pair is off, and so are `gate_flip` and `dump_close`.
- R5: Breaking mode holds while |i_line| > i_tol. Once the current is inside that band and the fast timer has expired, the gates go off, `trip_count` increments and the mode becomes 2 (isolating). In mode 2 all eight switch outputs are 0.
- R6: Isolating waits SLOW_MS ticks and then reads the capacitor. If the voltage is positive and within rated ± v_tol, the mode goes to 5. If |v_cap| > v_rated + v_tol, it goes to 3. Otherwise it goes to 4.
- R7: Discharging closes only `dump_close`. It lasts at least FAST_MS ticks and until |v_cap| ≤ v_rated + v_tol, then goes to 4, or to 5 if the voltage is already positive and in band.
- R8: Reversing gates only `gate_flip`. It lasts until v_cap > v_tol (positive polarity), then goes to 5.
- R9: Reclosing waits SLOW_MS ticks and then returns to mode 0.
- R10: A state that loads the timer with N (breaking: FAST_MS, isolating: SLOW_MS) leaves on the first clock edge after the edge that samples the Nth tick, and not earlier.
- R11: An interruption that completes while `trip_count` equals MAX_TRIPS (2) enters mode 6. In mode 6, `lockout` is 1, all switch outputs are 0 and `trip_count` keeps its value. The state is held regardless of the inputs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| i_line | input | IW | Signed line current, positive from terminal A to terminal B |
| v_cap | input | VW | Signed injection capacitor voltage |
| trip_lvl | input | IW | Unsigned trip magnitude |
| i_tol | input | IW | Unsigned zero-current band |
| v_rated | input | VW | Unsigned rated pre-charge magnitude (positive polarity) |
| v_tol | input | VW | Unsigned voltage band |
| disc_close | output | 1 | Residual disconnector close command |
| main_close | output | 1 | Main fast switch close command |
| dump_close | output | 1 | Discharge resistor switch close command |
| gate_pos_a | output | 1 | Positive-fault thyristor gate A |
| gate_pos_b | output | 1 | Positive-fault thyristor gate B |
| gate_neg_a | output | 1 | Negative-fault thyristor gate A |
| gate_neg_b | output | 1 | Negative-fault thyristor gate B |
| gate_flip | output | 1 | Capacitor polarity-reversal thyristor gate |
| mode | output | 3 | Present mode code |
| fault_neg | output | 1 | Direction of the last fault, 1 for negative |
| trip_count | output | CW | Completed interruptions |
| lockout | output | 1 | Breaker locked open |

## Verification
The mode and every switch output are decoded from one state register. A change in current or voltage therefore shows up exactly one clock edge after the sample that causes it. Every state that waits on a mechanical timer moves on the edge after the one that samples its last tick. The bench changes inputs and pulses the tick on falling edges, and reads results on the falling edge after the edge where the change is due. For each timed wait it checks once after N−1 ticks, where the mode must be unchanged, and once after the Nth tick, where it must have moved. The trip level and both tolerance bands are probed at their exact edges and one step beyond them, and the full open/close-open/close-open sequence is driven into lockout.

// File: rtl/dc_breaker_seq.sv
module dc_breaker_seq #(
  parameter int IW        = 16,
  parameter int VW        = 16,
  parameter int FAST_MS   = 2,
  parameter int SLOW_MS   = 20,
  parameter int MAX_TRIPS = 2,
  localparam int CW = $clog2(MAX_TRIPS + 1),
  localparam int TW = $clog2(((FAST_MS > SLOW_MS) ? FAST_MS : SLOW_MS) + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ms_tick,
  input  logic signed [IW-1:0] i_line,
  input  logic signed [VW-1:0] v_cap,
  input  logic [IW-1:0]        trip_lvl,
  input  logic [IW-1:0]        i_tol,
  input  logic [VW-1:0]        v_rated,
  input  logic [VW-1:0]        v_tol,
  output logic                 disc_close,
  output logic                 main_close,
  output logic                 dump_close,
  output logic                 gate_pos_a,
  output logic                 gate_pos_b,
  output logic                 gate_neg_a,
  output logic                 gate_neg_b,
  output logic                 gate_flip,
  output logic [2:0]           mode,
  output logic                 fault_neg,
  output logic [CW-1:0]        trip_count,
  output logic                 lockout
);

  localparam logic [2:0] M_NORM = 3'd0;
  localparam logic [2:0] M_BRK  = 3'd1;
  localparam logic [2:0] M_ISO  = 3'd2;
  localparam logic [2:0] M_DSCH = 3'd3;
  localparam logic [2:0] M_REV  = 3'd4;
  localparam logic [2:0] M_RECL = 3'd5;
  localparam logic [2:0] M_LOCK = 3'd6;

  logic [2:0]    st, nx;
  logic [TW-1:0] tmr, ld;
  logic          ld_en;
  logic          neg_q;
  logic [CW-1:0] cnt;
  logic [IW:0]   i_mag;
  logic [VW+1:0] v_mag;

  assign i_mag = i_line[IW-1] ? ({1'b0, ~i_line} + {{IW{1'b0}}, 1'b1}) : {1'b0, i_line};
  assign v_mag = v_cap[VW-1]  ? ({2'b0, ~v_cap} + {{(VW+1){1'b0}}, 1'b1}) : {2'b0, v_cap};

  wire trip     = i_mag > {1'b0, trip_lvl};
  wire i_zero   = i_mag <= {1'b0, i_tol};
  wire v_over   = v_mag > ({2'b0, v_rated} + {2'b0, v_tol});
  wire v_under  = (v_mag + {2'b0, v_tol}) < {2'b0, v_rated};
  wire v_ready  = !v_cap[VW-1] && !v_over && !v_under;
  wire v_pos    = !v_cap[VW-1] && (v_mag > {2'b0, v_tol});
  wire t_done   = tmr == '0;
  wire at_limit = cnt == CW'(MAX_TRIPS);

  always_comb begin
    nx    = st;
    ld_en = 1'b0;
    ld    = '0;
    case (st)
      M_NORM: if (trip) begin nx = M_BRK; ld_en = 1'b1; ld = TW'(FAST_MS); end
      M_BRK: if (t_done && i_zero) begin
        nx = at_limit ? M_LOCK : M_ISO; ld_en = 1'b1; ld = TW'(SLOW_MS);
      end
      M_ISO: if (t_done) begin
        if (v_ready)     begin nx = M_RECL; ld_en = 1'b1; ld = TW'(SLOW_MS); end
        else if (v_over) begin nx = M_DSCH; ld_en = 1'b1; ld = TW'(FAST_MS); end
        else             nx = M_REV;
      end
      M_DSCH: if (t_done && !v_over) begin
        if (v_ready) begin nx = M_RECL; ld_en = 1'b1; ld = TW'(SLOW_MS); end
        else         nx = M_REV;
      end
      M_REV:  if (v_pos)  begin nx = M_RECL; ld_en = 1'b1; ld = TW'(SLOW_MS); end
      M_RECL: if (t_done) nx = M_NORM;
      default: nx = M_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= M_NORM;
      tmr   <= '0;
      neg_q <= 1'b0;
      cnt   <= '0;
    end else begin
      st <= nx;
      if (ld_en)                 tmr <= ld;
      else if (ms_tick && !t_done) tmr <= tmr - TW'(1);
      if (st == M_NORM && trip)  neg_q <= i_line[IW-1];
      if (st == M_BRK && nx == M_ISO) cnt <= cnt + CW'(1);
    end
  end

  assign disc_close = (st == M_NORM) || (st == M_BRK) || (st == M_RECL);
  assign main_close = (st == M_NORM) || (st == M_RECL);
  assign dump_close = st == M_DSCH;
  assign gate_pos_a = (st == M_BRK) && !neg_q;
  assign gate_pos_b = (st == M_BRK) && !neg_q;
  assign gate_neg_a = (st == M_BRK) && neg_q;
  assign gate_neg_b = (st == M_BRK) && neg_q;
  assign gate_flip  = st == M_REV;
  assign mode       = st;
  assign fault_neg  = neg_q;
  assign trip_count = cnt;
  assign lockout    = st == M_LOCK;

  assert_trip_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_NORM && i_mag > {1'b0, trip_lvl}) |=> (!main_close && (gate_pos_a || gate_neg_a)));

  assert_pair_matches_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_pos_a) |-> !$past(i_line[IW-1]));

  assert_dir_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_BRK) |=> (st != M_BRK || $stable(fault_neg)));

  assert_break_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_BRK && i_mag > {1'b0, i_tol}) |=> (st == M_BRK));

  assert_timer_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == M_BRK || st == M_ISO || st == M_DSCH || st == M_RECL) && tmr != '0 && !ms_tick)
      |=> $stable(st));

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_LOCK) |=> (st == M_LOCK && $stable(trip_count)));

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_TRIPS));

endmodule

// File: tb/dc_breaker_seq_tb.sv
module dc_breaker_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic signed [15:0] i_line = '0;
  logic signed [15:0] v_cap = 16'sd500;
  logic [15:0] trip_lvl = 16'd1000;
  logic [15:0] i_tol = 16'd10;
  logic [15:0] v_rated = 16'd500;
  logic [15:0] v_tol = 16'd20;
  logic disc_close, main_close, dump_close;
  logic gate_pos_a, gate_pos_b, gate_neg_a, gate_neg_b, gate_flip;
  logic [2:0] mode;
  logic fault_neg, lockout;
  logic [1:0] trip_count;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dc_breaker_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .i_line(i_line), .v_cap(v_cap),
    .trip_lvl(trip_lvl), .i_tol(i_tol), .v_rated(v_rated), .v_tol(v_tol),
    .disc_close(disc_close), .main_close(main_close), .dump_close(dump_close),
    .gate_pos_a(gate_pos_a), .gate_pos_b(gate_pos_b), .gate_neg_a(gate_neg_a),
    .gate_neg_b(gate_neg_b), .gate_flip(gate_flip), .mode(mode),
    .fault_neg(fault_neg), .trip_count(trip_count), .lockout(lockout)
  );

  function automatic int exp_pat(input int m, input bit neg);
    case (m)
      0, 5: return 8'b1100_0000;
      1:    return {1'b1, 1'b0, 1'b0, !neg, !neg, neg, neg, 1'b0};
      3:    return 8'b0010_0000;
      4:    return 8'b0000_0001;
      default: return 0;
    endcase
  endfunction

  function automatic int pat();
    return int'({disc_close, main_close, dump_close, gate_pos_a, gate_pos_b,
                 gate_neg_a, gate_neg_b, gate_flip});
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      ms_tick = 1'b1; @(negedge clk);
      ms_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic chk_mode(input string tag, input int m, input bit neg);
    chk({tag, " mode"}, int'(mode), m);
    chk({tag, " switches"}, pat(), exp_pat(m, neg));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset count", int'(trip_count), 0);
    chk("R1 reset lockout", int'(lockout), 0);
    rst_n = 1'b1;
    step(1);
    chk_mode("R2 normal", 0, 1'b0);

    for (int k = -4; k <= 4; k++) begin
      i_line = 16'(k * 250);
      step(1);
      chk("R3 no trip at or below level", int'(mode), 0);
    end

    i_line = 16'sd1001;
    step(1);
    chk_mode("R3 R4 positive trip", 1, 1'b0);
    chk("R4 direction positive", int'(fault_neg), 0);
    tick(2);
    chk("R5 hold while current flows", int'(mode), 1);
    i_line = 16'sd5;
    v_cap = -16'sd1400;
    step(1);
    chk_mode("R5 isolating", 2, 1'b0);
    chk("R5 count after first", int'(trip_count), 1);
    i_line = '0;
    tick(19);
    chk("R10 isolating before last tick", int'(mode), 2);
    tick(1);
    chk_mode("R6 R7 over-voltage to discharge", 3, 1'b0);
    tick(2);
    chk("R7 discharge holds above band", int'(mode), 3);
    v_cap = -16'sd520;
    step(1);
    chk_mode("R7 R8 band edge to reverse", 4, 1'b0);
    v_cap = 16'sd5;
    step(2);
    chk("R8 reverse holds inside tolerance", int'(mode), 4);
    v_cap = 16'sd21;
    step(1);
    chk_mode("R8 R9 positive to reclose", 5, 1'b0);
    tick(19);
    chk("R9 reclose before last tick", int'(mode), 5);
    tick(1);
    chk_mode("R9 back to normal", 0, 1'b0);

    v_cap = 16'sd500;
    i_line = -16'sd1000;
    step(1);
    chk("R3 negative at level no trip", int'(mode), 0);
    i_line = -16'sd1001;
    step(1);
    chk_mode("R3 R4 negative trip", 1, 1'b1);
    chk("R4 direction negative", int'(fault_neg), 1);
    i_line = '0;
    tick(1);
    chk("R10 breaking before fast timer", int'(mode), 1);
    tick(1);
    chk("R10 breaking exits after fast timer", int'(mode), 2);
    chk("R5 count after second", int'(trip_count), 2);
    v_cap = -16'sd490;
    tick(20);
    chk_mode("R6 in-band negative to reverse", 4, 1'b1);
    v_cap = 16'sd500;
    step(1);
    chk("R8 reverse to reclose", int'(mode), 5);
    tick(20);
    chk("R9 normal after second reclose", int'(mode), 0);

    i_line = 16'sd2000;
    step(1);
    chk_mode("R4 third trip", 1, 1'b0);
    i_line = -16'sd3;
    tick(2);
    chk_mode("R11 lockout entered", 6, 1'b0);
    chk("R11 lockout flag", int'(lockout), 1);
    chk("R11 count held", int'(trip_count), 2);
    i_line = 16'sd5000;
    v_cap = -16'sd2000;
    tick(25);
    chk_mode("R11 lockout ignores inputs", 6, 1'b0);
    chk("R11 count still held", int'(trip_count), 2);

    rst_n = 1'b0;
    i_line = '0;
    v_cap = 16'sd500;
    step(2);
    chk("R1 reset clears lockout", int'(lockout), 0);
    chk("R1 reset clears count", int'(trip_count), 0);
    rst_n = 1'b1;
    step(1);
    chk_mode("R1 R2 normal after reset", 0, 1'b0);

    i_line = -16'sd1500;
    step(1);
    chk("R4 trip after reset", int'(mode), 1);
    i_line = 16'sd10;
    tick(2);
    chk("R5 tolerance edge ends break", int'(mode), 2);
    v_cap = 16'sd520;
    tick(20);
    chk_mode("R6 ready capacitor skips recovery", 5, 1'b1);
    tick(20);
    chk("R9 normal after skip", int'(mode), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule